// File: doc/BRIEF.md
# Indirect-Store and Branch Bus-Cycle Sequencer

This block steps an 8-bit processor core through a small set of instructions and reproduces every bus cycle they make. Each cycle it drives a 16-bit address, a read/write strobe and write data. It captures read data from memory at the end of that cycle. The instructions are an indexed store through a zero-page pointer, the eight flag-tested relative branches, and two immediate loads that set the accumulator and the index register. Any other opcode runs as a two-cycle no-operation.

The block exists to show the exact access pattern, not only the final result. Some cycles do reads that the instruction does not need: a read at the effective address before the carry reaches its high byte, and opcode fetches while a branch target is being built. A peripheral that reacts to reads sees these accesses. A bench or a system model can compare the bus trace cycle by cycle and find where each instruction begins from the `sync` pulse.

Top module: `busCycleSeq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the bus reads at the reset address (parameter RESET_PC) with `sync` high. A and Y reset to zero.
- R2: Every instruction begins with an opcode read at PC with `sync` high, after which PC advances by one. `sync` is high in no other cycle, and every instruction lasts at least two cycles.
- R3: Opcode 0x91 (indexed store through a pointer) reads the pointer byte at PC in cycle 2 and advances PC. Cycle 3 reads the pointer low byte at 0x00:ptr. Cycle 4 reads the high byte at 0x00:((ptr+1) mod 256), so the pointer wraps inside page zero.
- R4: In cycle 5 of opcode 0x91 the bus always reads at {pointer high, (pointer low + Y) mod 256}. This read happens even when the addition gives no carry.
- R5: Cycle 6 of opcode 0x91 writes A to the 16-bit sum of the pointer and Y. This is the only write of the instruction, and the next cycle is an opcode fetch.
- R6: Opcode 0xA9 loads A and opcode 0xA0 loads Y from the byte at PC in cycle 2. Both take two cycles.
- R7: A branch (opcode bits [4:0] = 10000) reads its offset at PC in cycle 2 and advances PC. When the branch is not taken, the next cycle is the fetch at the following instruction.
- R8: A taken branch reads at the advanced PC in cycle 3. If the target, which is the advanced PC plus the sign-extended offset, stays in the same 256-byte page, the next cycle fetches at the target.
- R9: When a taken branch changes page, cycle 4 reads at {old page, target low byte} before fetching at the target. This holds for forward and backward branches.
- R10: A branch is taken when flags[opcode[7:6]] equals opcode[5]. The flag input bits are flags[0]=negative, flags[1]=overflow, flags[2]=carry and flags[3]=zero.
- R11: Any other opcode runs in two cycles, with cycle 2 reading at PC without advancing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdData | input | 8 | Read data for the current cycle's address, captured at the rising edge |
| flags | input | 4 | Condition flags {zero, carry, overflow, negative} that branches test |
| addr | output | 16 | Bus address of the current cycle |
| rw | output | 1 | 1 = read cycle, 0 = write cycle |
| wrData | output | 8 | Write data (the accumulator) |
| sync | output | 1 | High in the opcode-fetch cycle that begins an instruction |

## Verification
The assertions check, on every cycle, the properties that do not depend on the program. A fetch is always a read. Instructions never last one cycle. Every write follows a non-fetch read at the same low address byte, with a high byte equal or one lower, and the cycle after a write is a fetch. The exact addresses of the pointer fetches, the zero-page wrap, whether a branch is taken for each flag encoding, the extra branch cycles at a page change and the values written to memory depend on program contents. Only the bench's scoreboard shows these, by comparing the whole bus trace against one built from the requirements.

// File: rtl/busCycleSeqPkg.sv
package busCycleSeqPkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PAGE_W = ADDR_W - DATA_W;

  localparam logic [DATA_W-1:0] OP_STORE_PTR_Y = 8'h91;
  localparam logic [DATA_W-1:0] OP_LOAD_ACC    = 8'hA9;
  localparam logic [DATA_W-1:0] OP_LOAD_IDX    = 8'hA0;
  localparam logic [4:0]        BRANCH_LOW     = 5'b10000;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_PTR_ADDR,
    ST_PTR_LO,
    ST_PTR_HI,
    ST_DUMMY_RD,
    ST_STORE,
    ST_IMM,
    ST_IDLE_RD,
    ST_BR_OFF,
    ST_BR_ADD,
    ST_BR_FIX
  } seqState_e;

  typedef enum logic [1:0] {
    SRC_PC,
    SRC_ZP,
    SRC_ZP_NEXT,
    SRC_EA
  } addrSrc_e;

  typedef struct packed {
    addrSrc_e addrSrc;
    logic     doWrite;
    logic     sync;
    logic     pcInc;
    logic     irLoad;
    logic     zpLoad;
    logic     eaLoLoad;
    logic     eaHiLoad;
    logic     eaFix;
    logic     accLoad;
    logic     idxLoad;
    logic     offLoad;
    logic     brAdd;
    logic     brFix;
  } seqCtl_t;

endpackage

// File: rtl/busCycleSeqDatapath.sv
module busCycleSeqDatapath
  import busCycleSeqPkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0400
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] addr,
  output logic              rw,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] opcode,
  output logic              pageCross
);

  logic [ADDR_W-1:0] pcReg;
  logic [DATA_W-1:0] accReg;
  logic [DATA_W-1:0] idxReg;
  logic [DATA_W-1:0] irReg;
  logic [DATA_W-1:0] zpReg;
  logic [DATA_W-1:0] eaLo;
  logic [PAGE_W-1:0] eaHi;
  logic              eaCarry;
  logic [DATA_W-1:0] offReg;

  logic [DATA_W-1:0] zpNext;
  logic [DATA_W:0]   idxSum;
  logic [ADDR_W-1:0] brTarget;

  // Pointer high byte stays in page zero.
  assign zpNext   = zpReg + 8'd1;
  // Only the low byte is summed; the carry waits a cycle.
  assign idxSum   = {1'b0, eaLo} + {1'b0, idxReg};
  // Full 16-bit target from the advanced PC and the sign-extended offset.
  assign brTarget = pcReg + {{PAGE_W{offReg[DATA_W-1]}}, offReg};
  assign pageCross = (brTarget[ADDR_W-1:DATA_W] != pcReg[ADDR_W-1:DATA_W]);

  always_comb begin
    unique case (ctl.addrSrc)
      SRC_PC:      addr = pcReg;
      SRC_ZP:      addr = {{PAGE_W{1'b0}}, zpReg};
      SRC_ZP_NEXT: addr = {{PAGE_W{1'b0}}, zpNext};
      SRC_EA:      addr = {eaHi, eaLo};
      default:     addr = pcReg;
    endcase
  end

  assign rw     = ~ctl.doWrite;
  assign wrData = accReg;
  assign opcode = irReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg <= RESET_PC;
    end else if (ctl.pcInc) begin
      pcReg <= pcReg + 16'd1;
    end else if (ctl.brAdd) begin
      pcReg[DATA_W-1:0] <= brTarget[DATA_W-1:0];
    end else if (ctl.brFix) begin
      pcReg[ADDR_W-1:DATA_W] <= eaHi;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg <= '0;
      idxReg <= '0;
      irReg  <= '0;
      zpReg  <= '0;
      offReg <= '0;
    end else begin
      if (ctl.irLoad)  irReg  <= rdData;
      if (ctl.zpLoad)  zpReg  <= rdData;
      if (ctl.accLoad) accReg <= rdData;
      if (ctl.idxLoad) idxReg <= rdData;
      if (ctl.offLoad) offReg <= rdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaLo    <= '0;
      eaHi    <= '0;
      eaCarry <= 1'b0;
    end else begin
      if (ctl.eaLoLoad) begin
        eaLo <= rdData;
      end
      if (ctl.eaHiLoad) begin
        eaHi    <= rdData;
        eaLo    <= idxSum[DATA_W-1:0];
        eaCarry <= idxSum[DATA_W];
      end
      if (ctl.eaFix) begin
        eaHi <= eaHi + {{(PAGE_W-1){1'b0}}, eaCarry};
      end
      if (ctl.brAdd) begin
        // eaHi holds the target page until the fix-up cycle.
        eaHi <= brTarget[ADDR_W-1:DATA_W];
      end
    end
  end

endmodule

// File: rtl/busCycleSeqControl.sv
module busCycleSeqControl
  import busCycleSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] opcode,
  input  logic [3:0]        flags,
  input  logic              pageCross,
  output seqCtl_t           ctl
);

  seqState_e state;
  seqState_e stateNext;
  logic      brTaken;

  // The opcode's top two bits pick a flag; bit 5 is the value that takes the branch.
  assign brTaken = (flags[opcode[7:6]] == opcode[5]);

  always_comb begin
    ctl       = '0;
    ctl.addrSrc = SRC_PC;
    stateNext = ST_FETCH;
    unique case (state)
      ST_FETCH: begin
        ctl.sync   = 1'b1;
        ctl.pcInc  = 1'b1;
        ctl.irLoad = 1'b1;
        if (rdData == OP_STORE_PTR_Y) begin
          stateNext = ST_PTR_ADDR;
        end else if (rdData == OP_LOAD_ACC || rdData == OP_LOAD_IDX) begin
          stateNext = ST_IMM;
        end else if (rdData[4:0] == BRANCH_LOW) begin
          stateNext = ST_BR_OFF;
        end else begin
          stateNext = ST_IDLE_RD;
        end
      end
      ST_PTR_ADDR: begin
        ctl.pcInc  = 1'b1;
        ctl.zpLoad = 1'b1;
        stateNext  = ST_PTR_LO;
      end
      ST_PTR_LO: begin
        ctl.addrSrc  = SRC_ZP;
        ctl.eaLoLoad = 1'b1;
        stateNext    = ST_PTR_HI;
      end
      ST_PTR_HI: begin
        ctl.addrSrc  = SRC_ZP_NEXT;
        ctl.eaHiLoad = 1'b1;
        stateNext    = ST_DUMMY_RD;
      end
      ST_DUMMY_RD: begin
        ctl.addrSrc = SRC_EA;
        ctl.eaFix   = 1'b1;
        stateNext   = ST_STORE;
      end
      ST_STORE: begin
        ctl.addrSrc = SRC_EA;
        ctl.doWrite = 1'b1;
        stateNext   = ST_FETCH;
      end
      ST_IMM: begin
        ctl.pcInc   = 1'b1;
        ctl.accLoad = (opcode == OP_LOAD_ACC);
        ctl.idxLoad = (opcode != OP_LOAD_ACC);
        stateNext   = ST_FETCH;
      end
      ST_IDLE_RD: begin
        stateNext = ST_FETCH;
      end
      ST_BR_OFF: begin
        ctl.pcInc   = 1'b1;
        ctl.offLoad = 1'b1;
        stateNext   = brTaken ? ST_BR_ADD : ST_FETCH;
      end
      ST_BR_ADD: begin
        ctl.brAdd = 1'b1;
        stateNext = pageCross ? ST_BR_FIX : ST_FETCH;
      end
      ST_BR_FIX: begin
        ctl.brFix = 1'b1;
        stateNext = ST_FETCH;
      end
      default: begin
        stateNext = ST_FETCH;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= stateNext;
  end

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busCycleSeqPkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rdData,
  input  logic [3:0]        flags,
  output logic [ADDR_W-1:0] addr,
  output logic              rw,
  output logic [DATA_W-1:0] wrData,
  output logic              sync
);

  seqCtl_t           ctl;
  logic [DATA_W-1:0] opcode;
  logic              pageCross;

  busCycleSeqControl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .rdData    (rdData),
    .opcode    (opcode),
    .flags     (flags),
    .pageCross (pageCross),
    .ctl       (ctl)
  );

  busCycleSeqDatapath #(.RESET_PC(RESET_PC)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .rdData    (rdData),
    .addr      (addr),
    .rw        (rw),
    .wrData    (wrData),
    .opcode    (opcode),
    .pageCross (pageCross)
  );

  assign sync = ctl.sync;

endmodule

// File: rtl/busCycleSeqChecker.sv
module busCycleSeqChecker (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] addr,
  input logic        rw,
  input logic        sync
);

  AST_FETCH_IS_READ: assert property (@(posedge clk) disable iff (!rstN)
    sync |-> rw); // R2

  AST_NO_ONE_CYCLE_INSN: assert property (@(posedge clk) disable iff (!rstN)
    sync |=> !sync); // R2

  AST_WRITE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    !rw |=> sync); // R5

  AST_DUMMY_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !rw |-> ($past(rw) && !$past(sync))); // R4

  AST_DUMMY_SAME_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !rw |-> (addr[7:0] == $past(addr[7:0]))); // R4

  AST_DUMMY_HIGH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !rw |-> ((addr[15:8] == $past(addr[15:8])) ||
             (addr[15:8] == ($past(addr[15:8]) + 8'd1)))); // R4

endmodule

bind busCycleSeq busCycleSeqChecker uChk (
  .clk  (clk),
  .rstN (rstN),
  .addr (addr),
  .rw   (rw),
  .sync (sync)
);

// File: tb/sim_busCycleSeq.sv
`timescale 1ns/1ps
module sim_busCycleSeq;

  localparam logic [15:0] START_PC = 16'h04C0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  rdData = 8'h00;
  // {zero, carry, overflow, negative} = {0,1,0,1}
  logic [3:0]  flags = 4'b0101;
  logic [15:0] addr;
  logic        rw;
  logic [7:0]  wrData;
  logic        sync;

  always #2 clk = ~clk;

  busCycleSeq #(.RESET_PC(START_PC)) u0 (
    .clk(clk), .rstN(rstN), .rdData(rdData), .flags(flags),
    .addr(addr), .rw(rw), .wrData(wrData), .sync(sync)
  );

  logic [7:0]  mem [logic [15:0]];
  logic [15:0] qAddr [$];
  logic        qRw [$];
  logic [7:0]  qWd [$];
  logic        qSync [$];
  string       qTag [$];

  int          checks = 0;
  int          errors = 0;
  bit          running = 0;
  bit          done = 0;
  logic [15:0] pcM;
  logic [7:0]  accM;
  logic [7:0]  idxM;

  function automatic logic [7:0] memRd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic putByte(input logic [15:0] a, input logic [7:0] v);
    mem[a] = v;
  endtask

  task automatic pushExp(input logic [15:0] a, input logic r, input logic [7:0] wd,
                         input logic s, input string tag);
    qAddr.push_back(a); qRw.push_back(r); qWd.push_back(wd);
    qSync.push_back(s); qTag.push_back(tag);
  endtask

  task automatic opLoad(input logic [7:0] op, input logic [7:0] v);
    putByte(pcM, op); putByte(pcM + 16'd1, v);
    pushExp(pcM, 1'b1, 8'h00, 1'b1, "R2");
    pushExp(pcM + 16'd1, 1'b1, 8'h00, 1'b0, "R6");
    if (op == 8'hA9) accM = v; else idxM = v;
    pcM = pcM + 16'd2;
  endtask

  task automatic opStore(input logic [7:0] zp, input logic [15:0] ptr);
    logic [7:0]  zp1;
    logic [8:0]  lo;
    zp1 = zp + 8'd1;
    putByte(pcM, 8'h91); putByte(pcM + 16'd1, zp);
    putByte({8'h00, zp}, ptr[7:0]); putByte({8'h00, zp1}, ptr[15:8]);
    pushExp(pcM, 1'b1, 8'h00, 1'b1, "R2");
    pushExp(pcM + 16'd1, 1'b1, 8'h00, 1'b0, "R3");
    pushExp({8'h00, zp}, 1'b1, 8'h00, 1'b0, "R3");
    pushExp({8'h00, zp1}, 1'b1, 8'h00, 1'b0, "R3");  // R3: wraps in page zero
    lo = {1'b0, ptr[7:0]} + {1'b0, idxM};
    pushExp({ptr[15:8], lo[7:0]}, 1'b1, 8'h00, 1'b0, "R4");
    pushExp(ptr + {8'h00, idxM}, 1'b0, accM, 1'b0, "R5");
    pcM = pcM + 16'd2;
  endtask

  task automatic opBranch(input logic [7:0] op, input logic [7:0] off, input logic taken);
    logic [15:0] np;
    logic [15:0] tgt;
    np = pcM + 16'd2;
    putByte(pcM, op); putByte(pcM + 16'd1, off);
    pushExp(pcM, 1'b1, 8'h00, 1'b1, "R10");
    pushExp(pcM + 16'd1, 1'b1, 8'h00, 1'b0, "R7");
    if (!taken) begin
      pcM = np;
    end else begin
      tgt = np + {{8{off[7]}}, off};
      pushExp(np, 1'b1, 8'h00, 1'b0, "R8");
      if (tgt[15:8] != np[15:8])
        pushExp({np[15:8], tgt[7:0]}, 1'b1, 8'h00, 1'b0, "R9");
      pcM = tgt;
    end
  endtask

  task automatic opOther(input logic [7:0] op);
    putByte(pcM, op);
    pushExp(pcM, 1'b1, 8'h00, 1'b1, "R2");
    pushExp(pcM + 16'd1, 1'b1, 8'h00, 1'b0, "R11");
    pcM = pcM + 16'd1;
  endtask

  task automatic checkMem(input logic [15:0] a, input logic [7:0] v, input string tag);
    checks++;
    if (memRd(a) !== v) begin
      errors++;
      $display("FAIL %s: mem[%h] actual %h expected %h", tag, a, memRd(a), v);
    end
  endtask

  // Monitor: pops one expected bus cycle per clock and compares.
  always @(negedge clk) begin : monitor
    logic [15:0] eA;
    logic        eR;
    logic [7:0]  eW;
    logic        eS;
    string       eT;
    if (running && qAddr.size() > 0) begin
      eA = qAddr.pop_front(); eR = qRw.pop_front(); eW = qWd.pop_front();
      eS = qSync.pop_front(); eT = qTag.pop_front();
      checks++;
      if (addr !== eA || rw !== eR || sync !== eS || (!eR && wrData !== eW)) begin
        errors++;
        $display("FAIL %s: actual addr=%h rw=%b sync=%b wd=%h expected addr=%h rw=%b sync=%b wd=%h",
                 eT, addr, rw, sync, wrData, eA, eR, eS, eW);
      end
      if (qAddr.size() == 0) done = 1;
    end
    if (rstN && rw === 1'b0) mem[addr] = wrData;
    rdData = memRd(addr);
  end

  initial begin
    pcM = START_PC; accM = 8'h00; idxM = 8'h00;
    opLoad(8'hA0, 8'h05);           // R6 load Y
    opLoad(8'hA9, 8'h3C);           // R6 load A
    opStore(8'h10, 16'h2010);       // R4 no carry, dummy read still present
    opLoad(8'hA0, 8'hF0);
    opLoad(8'hA9, 8'h77);
    opStore(8'hFF, 16'h3120);       // R3 pointer wrap, R4 carry into high byte
    opOther(8'hEA);                 // R11
    opBranch(8'h10, 8'h22, 1'b0);   // R10 negative clear test: not taken
    opBranch(8'h30, 8'h04, 1'b1);   // R8 same page
    opBranch(8'hB0, 8'h40, 1'b1);   // R9 forward page change
    opBranch(8'h70, 8'h11, 1'b0);   // R10 overflow set test: not taken
    opBranch(8'h90, 8'h11, 1'b0);   // R10 carry clear test: not taken
    opBranch(8'hF0, 8'h11, 1'b0);   // R10 zero set test: not taken
    opBranch(8'hD0, 8'h80, 1'b1);   // R9 backward page change
    opBranch(8'h50, 8'h02, 1'b1);   // R8 overflow clear test: taken
    opLoad(8'hA9, 8'hC3);
    opLoad(8'hA0, 8'h00);
    opStore(8'h20, 16'h12FF);       // R4 Y=0
    opLoad(8'hA0, 8'h01);
    opStore(8'h20, 16'h12FF);       // R4 carry: dummy at 0x1200
    pushExp(pcM, 1'b1, 8'h00, 1'b1, "R5");  // boundary after last store

    repeat (3) @(posedge clk);
    #1;
    checks++;  // R1 reset state
    if (addr !== START_PC || rw !== 1'b1 || sync !== 1'b1) begin
      errors++;
      $display("FAIL R1: actual addr=%h rw=%b sync=%b expected addr=%h rw=1 sync=1",
               addr, rw, sync, START_PC);
    end
    rstN = 1'b1;
    running = 1;

    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d items left expected 0", qAddr.size());
    end

    checkMem(16'h2015, 8'h3C, "R5");
    checkMem(16'h3210, 8'h77, "R5");
    checkMem(16'h1300, 8'hC3, "R5");
    checks++;  // R5: the dummy-read address is never written
    if (mem.exists(16'h3110)) begin
      errors++;
      $display("FAIL R5: actual write at 3110 expected none");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule